// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Buffer

This block is a two-wire bus slave that owns a 256-byte storage array. A bus master addresses it with the fixed 7-bit device code 1010000. It then either loads a word address and streams data bytes to be stored, or reads bytes back one at a time or as a continuous run. The bus lines arrive as plain inputs and are oversampled by the system clock. The block pulls SDA low through an open-drain enable output and never drives it high.

Written bytes collect in an eight-slot buffer tied to one aligned page of the array. A STOP copies the buffered slots into storage and begins a self-timed busy period, whose length is set by a parameter in clock cycles. During that period the slave stays silent on the bus, so a master can poll for completion. Writes are gated by a clock-level input that must stay high for the whole write transfer. A second gate, a write-protect level, takes effect only after a one-time internal flag is set, and that flag is set by storing any value at address 7Fh.

Top module: `eeprom_twi_slave`

## Requirements
- R1: Only a control byte whose upper seven bits are 1010000 is acknowledged; its last bit selects read (1) or write (0). Any other control byte gets no acknowledge, and the slave stays silent until the next START.
- R2: After a write control byte, the first byte received loads the word address and every following byte is data; all of them are acknowledged. A single data byte followed by STOP is stored at the word address.
- R3: Data bytes fill an eight-entry buffer. After each byte only the low three address bits advance and the upper five stay fixed, so a ninth or later byte overwrites earlier data within the same aligned page.
- R4: A STOP that follows at least one data byte starts a write period of WR_CYCLES clocks, during which no control byte is acknowledged, its own address included. A STOP after only a word address starts no write period.
- R5: If VCLK is low at any point between the START and the STOP of a write transfer, the buffered data is discarded and no write period starts. A VCLK change during a write period does not stop that write.
- R6: A read with no preceding word address returns the byte at the last accessed address plus one. A random read is a write header that carries only the word address, then a repeated START and a read control byte.
- R7: While the master acknowledges each read byte, the next byte follows from the next address. A NACK ends the transfer, and SDA is left released for the STOP.
- R8: A one-time flag is clear after reset and is set by any stored write to address 7Fh. While the flag is clear, WP has no effect. Once it is set, a write with WP low is discarded and starts no write period.
- R9: The read address wraps from FFh to 00h across the whole array.
- R10: SDA is released after reset, and the SDA drive changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| vclk_i | input | 1 | Write enable level; must stay high during write transfers |
| wp_i | input | 1 | Write-protect level, active low, pulled high when undriven |

## Verification
The hardest situations to reach from the ports are the ones that hinge on timing and history: the slave refusing its own address during a write period, and a page write that wraps inside its page. The bench reaches the first by issuing a control byte right after the STOP of a write, then polling until the acknowledge comes back. It reaches the second with ten bytes starting mid-page, followed by a read of the whole page. The write-protect flag can only be armed by storing to 7Fh. The bench therefore first checks that WP low has no effect, then arms the flag, and checks that a write with WP low is discarded and triggers no write period.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } twi_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{INIT}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int DW = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DW-1:0]    slot_data [SLOTS];
  logic [SLOTS-1:0] slot_valid;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [DW-1:0] data_q;
    logic          valid_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
      end else if (clr) begin
        valid_q <= 1'b0;
      end else if (wr_en && wr_idx == PAGE_W'(i)) begin
        valid_q <= 1'b1;
        data_q  <= wr_data;
      end
    end
    assign slot_data[i]  = data_q;
    assign slot_valid[i] = valid_q;
  end

  assign rd_data   = slot_data[rd_idx];
  assign rd_valid  = slot_valid[rd_idx];
  assign any_valid = |slot_valid;
endmodule

// File: rtl/twi_mem.sv
module twi_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
  import twi_eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'b1010000,
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 3,
  parameter int         WR_CYCLES   = 1000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] PROT_ADDR   = 8'h7F
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic vclk_i,
  input  logic wp_i
);
  localparam int SLOTS  = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int TMR_W  = $clog2(WR_CYCLES);
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // line synchronization
  logic scl_s, sda_s, vclk_s, wp_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  twi_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'hF)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i, vclk_i, wp_i}),
    .q   ({scl_s, sda_s, vclk_s, wp_s})
  );

  twi_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl_s),
    .sda       (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // protocol state
  twi_state_e           state;
  logic [CNT_W-1:0]     bitcnt;
  logic [BYTE_W-1:0]    shreg;
  logic [BYTE_W-1:0]    tx;
  logic [ADDR_W-1:0]    ptr;
  logic                 rd_mode;
  logic                 master_ack;
  logic                 vclk_bad;

  // write-cycle state
  logic                 busy;
  logic                 committing;
  logic [TMR_W-1:0]     tmr;
  logic [PAGE_W-1:0]    cidx;
  logic [HI_W-1:0]      page_base;
  logic                 fuse;

  // memory and buffer wiring
  logic                 mem_we;
  logic [ADDR_W-1:0]    mem_addr;
  logic [BYTE_W-1:0]    mem_rdata;
  logic [BYTE_W-1:0]    pb_rd_data;
  logic                 pb_rd_valid;
  logic                 pb_any_valid;
  logic                 pb_wr_en;
  logic                 pb_clr;
  logic                 byte_in;
  logic                 write_ok;
  logic                 start_commit;

  assign byte_in  = scl_fall && (bitcnt == CNT_W'(BYTE_W)) && !start_det && !stop_det;
  assign pb_wr_en = (state == ST_WDATA) && byte_in;
  assign write_ok = !vclk_bad && vclk_s && (!fuse || wp_s);
  assign start_commit = stop_det && (state == ST_WDATA) && pb_any_valid && !busy && write_ok;
  assign pb_clr = (start_det && !busy)
                || (stop_det && !busy && !start_commit)
                || (committing && cidx == PAGE_W'(SLOTS - 1));

  twi_page_buf #(.DW(BYTE_W), .PAGE_W(PAGE_W)) u_page (
    .clk       (clk),
    .rst       (rst),
    .clr       (pb_clr),
    .wr_en     (pb_wr_en),
    .wr_idx    (ptr[PAGE_W-1:0]),
    .wr_data   (shreg),
    .rd_idx    (cidx),
    .rd_data   (pb_rd_data),
    .rd_valid  (pb_rd_valid),
    .any_valid (pb_any_valid)
  );

  assign mem_we   = committing && pb_rd_valid;
  assign mem_addr = committing ? {page_base, cidx} : ptr;

  twi_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (pb_rd_data),
    .rdata (mem_rdata)
  );

  // self-timed write period, commit of buffered slots, protect flag
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      committing <= 1'b0;
      tmr        <= '0;
      cidx       <= '0;
      page_base  <= '0;
      fuse       <= 1'b0;
    end else begin
      if (start_commit) begin
        busy       <= 1'b1;
        committing <= 1'b1;
        tmr        <= TMR_W'(WR_CYCLES - 1);
        cidx       <= '0;
        page_base  <= ptr[ADDR_W-1:PAGE_W];
      end else begin
        if (busy) begin
          if (tmr == '0) busy <= 1'b0;
          else           tmr  <= tmr - 1'b1;
        end
        if (committing) begin
          cidx <= cidx + 1'b1;
          if (cidx == PAGE_W'(SLOTS - 1)) committing <= 1'b0;
        end
      end
      if (mem_we && mem_addr == PROT_ADDR[ADDR_W-1:0]) fuse <= 1'b1;
    end
  end

  // bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      tx         <= '0;
      ptr        <= '0;
      rd_mode    <= 1'b0;
      master_ack <= 1'b0;
      vclk_bad   <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (start_det) begin
      state    <= ST_CTRL;
      bitcnt   <= '0;
      sda_oe   <= 1'b0;
      vclk_bad <= ~vclk_s;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      if (state != ST_IDLE && !vclk_s) vclk_bad <= 1'b1;
      case (state)
        ST_CTRL, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bitcnt < CNT_W'(BYTE_W)) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_in) begin
            bitcnt <= '0;
            if (state == ST_CTRL) begin
              if (shreg[BYTE_W-1:1] == DEV_ID && !busy) begin
                rd_mode <= shreg[0];
                sda_oe  <= 1'b1;
                state   <= ST_CTRL_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              ptr    <= shreg[ADDR_W-1:0];
              sda_oe <= 1'b1;
              state  <= ST_WADDR_ACK;
            end else begin
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              sda_oe          <= 1'b1;
              state           <= ST_WDATA_ACK;
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              tx     <= mem_rdata;
              sda_oe <= ~mem_rdata[BYTE_W-1];
              bitcnt <= '0;
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == CNT_W'(BYTE_W)) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RACK;
            end else begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ptr        <= ptr + 1'b1;
            master_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (master_ack) begin
              tx     <= mem_rdata;
              sda_oe <= ~mem_rdata[BYTE_W-1];
              state  <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_twi_chk.sv
module eeprom_twi_chk
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              busy,
  input logic              stop_det,
  input logic              mem_we,
  input logic              fuse,
  input twi_state_e        state,
  input logic [ADDR_W-1:0] ptr
);
  // R10: drive changes only while the clock line is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R4: silent on the bus during a write period
  p_busy_silent_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R4: a write period only begins on a STOP
  p_busy_from_stop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  // R4: array is written only inside a write period
  p_we_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R3: data bytes never move the page part of the pointer
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA_ACK && $past(state) == ST_WDATA)
      |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  // R8: the protect flag never clears once set
  p_fuse_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(fuse) |-> fuse);
endmodule

bind eeprom_twi_slave eeprom_twi_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .busy     (busy),
  .stop_det (stop_det),
  .mem_we   (mem_we),
  .fuse     (fuse),
  .state    (state),
  .ptr      (ptr)
);

// File: tb/eeprom_twi_slave_bench.sv
module eeprom_twi_slave_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic vclk = 1'b1;
  logic wp = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #2 clk = ~clk;

  eeprom_twi_slave u_eeprom_twi_slave (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe),
    .vclk_i (vclk),
    .wp_i   (wp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold(); hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold();
      scl_m = 1'b1; hold(); hold();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    ack = ~sda_bus;
    hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      scl_m = 1'b1; hold();
      d[i] = sda_bus;
      hold();
      scl_m = 1'b0;
    end
    sda_m = ~give_ack; hold();
    scl_m = 1'b1; hold(); hold();
    scl_m = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  task automatic write_bytes(input logic [7:0] a, input int n, input bit glitch, output bit ok);
    bit ack;
    ok = 1'b1;
    bus_start();
    send_byte(8'hA0, ack); ok &= ack;
    if (glitch) begin vclk = 1'b0; hold(); vclk = 1'b1; end
    send_byte(a, ack); ok &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); ok &= ack;
    end
    bus_stop();
  endtask

  task automatic read_random(input logic [7:0] a, input int n);
    bit ack;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(a, ack);
    bus_start();
    send_byte(8'hA1, ack);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic read_current(output logic [7:0] d);
    bit ack;
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic probe(output bit ack);
    bus_start();
    send_byte(8'hA0, ack);
    bus_stop();
  endtask

  task automatic wait_ready(output int polls);
    bit ack;
    polls = 0;
    for (int k = 0; k < 200; k++) begin
      probe(ack);
      if (ack) break;
      polls++;
    end
  endtask

  task automatic t_reset();
    chk("R10 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_address();
    bit ack;
    int polls;
    bus_start();
    send_byte(8'hA2, ack);
    chk("R1 foreign control byte not acked", ack, 0);
    bus_stop();
    chk("R1 bus released after foreign byte", sda_oe, 0);
    wait_ready(polls);
    chk("R1 own address acked when idle", polls, 0);
  endtask

  task automatic t_byte_write();
    bit ok, ack;
    int polls;
    logic [7:0] d;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    write_bytes(8'h10, 2, 1'b0, ok);
    chk("R2 header and data acked", ok, 1);
    probe(ack);
    chk("R4 own address refused during write period", ack, 0);
    wait_ready(polls);
    chk("R4 write period ends", (polls > 0 && polls < 200) ? 1 : 0, 1);
    read_random(8'h10, 1);
    chk("R2 random read of stored byte", rbuf[0], 8'hA5);
    read_current(d);
    chk("R6 current read returns next address", d, 8'h5A);
  endtask

  task automatic t_addr_only();
    bit ok, ack;
    write_bytes(8'h30, 0, 1'b0, ok);
    probe(ack);
    chk("R4 stop after word address only starts no write period", ack, 1);
  endtask

  task automatic t_page();
    bit ok;
    int polls;
    logic [7:0] d;
    logic [7:0] exp [8];
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hD0 + 8'(i);
    write_bytes(8'h23, 10, 1'b0, ok);
    wait_ready(polls);
    read_current(d);
    chk("R6 current read after wrapped page write", d, 8'hD2);
    exp = '{8'hD5, 8'hD6, 8'hD7, 8'hD8, 8'hD9, 8'hD2, 8'hD3, 8'hD4};
    read_random(8'h20, 8);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R3 R7 page slot %0d", i), rbuf[i], exp[i]);
    end
    chk("R7 sda released after NACK and STOP", sda_oe, 0);
  endtask

  task automatic t_vclk();
    bit ok, ack;
    int polls;
    wbuf[0] = 8'h33;
    write_bytes(8'h40, 1, 1'b0, ok);
    wait_ready(polls);
    wbuf[0] = 8'h11;
    write_bytes(8'h40, 1, 1'b1, ok);
    probe(ack);
    chk("R5 VCLK glitch starts no write period", ack, 1);
    read_random(8'h40, 1);
    chk("R5 VCLK glitch discards data", rbuf[0], 8'h33);
    wbuf[0] = 8'h66;
    write_bytes(8'h41, 1, 1'b0, ok);
    vclk = 1'b0;
    wait_ready(polls);
    vclk = 1'b1;
    read_random(8'h41, 1);
    chk("R5 VCLK low during write period does not abort", rbuf[0], 8'h66);
  endtask

  task automatic t_fuse();
    bit ok, ack;
    int polls;
    wp = 1'b0;
    wbuf[0] = 8'h77;
    write_bytes(8'h50, 1, 1'b0, ok);
    wait_ready(polls);
    read_random(8'h50, 1);
    chk("R8 WP ignored before flag set", rbuf[0], 8'h77);
    wp = 1'b1;
    wbuf[0] = 8'h5A;
    write_bytes(8'h7F, 1, 1'b0, ok);
    wait_ready(polls);
    wp = 1'b0;
    wbuf[0] = 8'h88;
    write_bytes(8'h50, 1, 1'b0, ok);
    probe(ack);
    chk("R8 protected write starts no write period", ack, 1);
    read_random(8'h50, 1);
    chk("R8 WP low blocks write after flag set", rbuf[0], 8'h77);
    wp = 1'b1;
    wbuf[0] = 8'h99;
    write_bytes(8'h50, 1, 1'b0, ok);
    wait_ready(polls);
    read_random(8'h50, 1);
    chk("R8 WP high allows write after flag set", rbuf[0], 8'h99);
  endtask

  task automatic t_wrap();
    bit ok;
    int polls;
    wbuf[0] = 8'hC3;
    write_bytes(8'hFF, 1, 1'b0, ok);
    wait_ready(polls);
    wbuf[0] = 8'h3C;
    write_bytes(8'h00, 1, 1'b0, ok);
    wait_ready(polls);
    read_random(8'hFF, 2);
    chk("R9 byte at FFh", rbuf[0], 8'hC3);
    chk("R9 sequential read wraps to 00h", rbuf[1], 8'h3C);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    t_address();
    t_byte_write();
    t_addr_only();
    t_page();
    t_vclk();
    t_fuse();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule